// File: doc/BRIEF.md
# Ethernet Receive Error Classifier

This block sits at the end of an Ethernet receive path and decides what each frame-end or drop event means. Each cycle it looks at the frame-end strobe, the CRC result sampled at the last whole octet, the number of bits left over past that octet, a receive FIFO overrun strobe and a no-buffer strobe. From these it produces a one-cycle report: a buffer-close strobe with per-buffer status flags, a receive-frame event, a busy event and a command that sends the receiver into hunt mode. It also keeps three saturating statistics counters: discarded frames, alignment errors and CRC errors.

In hunt mode every receive event is ignored until a start-of-frame delimiter arrives. An overrun means the FIFO overwrote its previous entry, so the frame status is lost. An overrun or a CRC failure on an octet-aligned frame therefore enters hunt mode. A frame that ends with dribbling bits counts as an alignment error only when the CRC at the last full octet fails. CRC checking is always on: no input turns it off. Software clears each counter on its own through a clear strobe.

Top module: `rxec_classifier`

## Requirements
- R1: After reset all three counters read zero, hunting is low, and buf_close, ev_rxf, ev_busy, hunt_cmd and st_flags are all zero.
- R2: An overrun strobe, outside hunt mode, produces the following one cycle later: buf_close, ev_rxf, st_flags = 3'b001 (bit 0 = overrun), hunt_cmd and hunting high, and one increment of the discard counter.
- R3: A no-buffer strobe, outside hunt mode and without an overrun, produces ev_busy and one discard-counter increment one cycle later. It produces no buf_close, no ev_rxf and no hunt entry.
- R4: A frame end with crc_ok low and res_bits equal to zero produces the following one cycle later: buf_close, ev_rxf, st_flags = 3'b010 (bit 1 = CRC error), a CRC-counter increment and hunt entry.
- R5: A frame end with crc_ok low and res_bits nonzero produces the following one cycle later: buf_close, ev_rxf, st_flags = 3'b100 (bit 2 = non-octet), an alignment-counter increment, no CRC-counter increment and no hunt entry.
- R6: A frame end with crc_ok high produces buf_close and ev_rxf with st_flags zero and no counter change, whatever the value of res_bits.
- R7: While hunting is high, frame-end, overrun and no-buffer strobes have no effect. A start-of-frame strobe while hunting clears hunting one cycle later.
- R8: When several strobes arrive in the same cycle, overrun takes precedence over no-buffer, and no-buffer takes precedence over frame end. Only one class is reported.
- R9: Each counter saturates at 2^CNT_W-1 and does not wrap.
- R10: ctr_clr bit 0 clears the discard counter, bit 1 the alignment counter and bit 2 the CRC counter one cycle later. A clear wins over a same-cycle increment.
- R11: All event and status outputs are single-cycle pulses, registered one cycle after the causing input, and st_flags is nonzero only together with buf_close.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof | input | 1 | Start-of-frame delimiter seen |
| frame_end | input | 1 | Frame ended this cycle |
| crc_ok | input | 1 | CRC check at last whole octet passed (valid with frame_end) |
| res_bits | input | RES_W | Bits received past the last whole octet (valid with frame_end) |
| fifo_ovr | input | 1 | Receive FIFO overrun strobe |
| no_buf | input | 1 | Frame dropped for lack of a buffer |
| ctr_clr | input | 3 | Per-counter clear: bit 0 discard, bit 1 alignment, bit 2 CRC |
| buf_close | output | 1 | Close the current buffer |
| st_flags | output | 3 | Buffer status: bit 0 overrun, bit 1 CRC error, bit 2 non-octet |
| ev_rxf | output | 1 | Receive-frame event |
| ev_busy | output | 1 | Busy event |
| hunt_cmd | output | 1 | Command to enter hunt mode |
| hunting | output | 1 | Receiver is in hunt mode |
| cnt_discard | output | CNT_W | Discarded-frame counter |
| cnt_align | output | CNT_W | Alignment-error counter |
| cnt_crc | output | CNT_W | CRC-error counter |

## Verification
Several properties are checked on every cycle:
- the counters saturate without wrapping and step by exactly one;
- a clear empties a counter;
- hunting holds until a delimiter arrives;
- a frame end during hunting closes no buffer;
- status flags appear only with a buffer close;
- a busy report never closes a buffer;
- a hunt command always leaves the receiver hunting.

Other behaviour needs the bench's sweeps, which compare against an arithmetic model:
- which class wins for each combination of simultaneous strobes;
- the exact flag code and which counter moves for every residual-bit count with the CRC passing or failing;
- the rule that an alignment error skips the CRC counter.

// File: rtl/rxec_pkg.sv
package rxec_pkg;
   localparam int NUM_CNT  = 3;
   localparam int FLG_OV   = 0;
   localparam int FLG_CR   = 1;
   localparam int FLG_NO   = 2;
   localparam int CNT_DISC = 0;
   localparam int CNT_ALGN = 1;
   localparam int CNT_CRC  = 2;

   typedef enum logic [2:0] {
      CLS_NONE,
      CLS_OVERRUN,
      CLS_BUSY,
      CLS_CRCERR,
      CLS_ALIGN,
      CLS_GOOD
   } cls_e;

   typedef struct packed {
      logic               close;
      logic               rxf;
      logic               busy;
      logic               hunt;
      logic [2:0]         flags;
      logic [NUM_CNT-1:0] inc;
   } act_t;
endpackage

// File: rtl/rxec_decide.sv
module rxec_decide
   import rxec_pkg::*;
#(
   parameter int RES_W = 3
) (
   input  logic             hunting,
   input  logic             fifo_ovr,
   input  logic             no_buf,
   input  logic             frame_end,
   input  logic             crc_ok,
   input  logic [RES_W-1:0] res_bits,
   output act_t             act
);
   cls_e cls;
   logic non_octet;

   assign non_octet = |res_bits;

   always_comb begin
      cls = CLS_NONE;
      if (!hunting) begin
         if (fifo_ovr)                   cls = CLS_OVERRUN;
         else if (no_buf)                cls = CLS_BUSY;
         else if (frame_end && crc_ok)   cls = CLS_GOOD;
         else if (frame_end && non_octet) cls = CLS_ALIGN;
         else if (frame_end)             cls = CLS_CRCERR;
      end
   end

   always_comb begin
      act = '0;
      case (cls)
         CLS_OVERRUN: begin
            act.close          = 1'b1;
            act.rxf            = 1'b1;
            act.hunt           = 1'b1;
            act.flags[FLG_OV]  = 1'b1;
            act.inc[CNT_DISC]  = 1'b1;
         end
         CLS_BUSY: begin
            act.busy           = 1'b1;
            act.inc[CNT_DISC]  = 1'b1;
         end
         CLS_CRCERR: begin
            act.close          = 1'b1;
            act.rxf            = 1'b1;
            act.hunt           = 1'b1;
            act.flags[FLG_CR]  = 1'b1;
            act.inc[CNT_CRC]   = 1'b1;
         end
         CLS_ALIGN: begin
            act.close          = 1'b1;
            act.rxf            = 1'b1;
            act.flags[FLG_NO]  = 1'b1;
            act.inc[CNT_ALGN]  = 1'b1;
         end
         CLS_GOOD: begin
            act.close          = 1'b1;
            act.rxf            = 1'b1;
         end
         default: act = '0;
      endcase
   end
endmodule

// File: rtl/rxec_hunt.sv
module rxec_hunt (
   input  logic clk,
   input  logic rst_n,
   input  logic enter,
   input  logic sof,
   output logic hunting
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                hunting <= 1'b0;
      else if (enter)            hunting <= 1'b1;
      else if (hunting && sof)   hunting <= 1'b0;
   end

   assert_hunt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hunting && !sof) |=> hunting);
   assert_hunt_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hunting && sof && !enter) |=> !hunting);
endmodule

// File: rtl/rxec_satcnt.sv
module rxec_satcnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         clr,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  q <= '0;
      else if (clr)                q <= '0;
      else if (inc && q != TOP)    q <= q + 1'b1;
   end

   assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (q == TOP && !clr) |=> q == TOP);
   assert_step_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && q != TOP) |=> q == $past(q) + 1'b1);
   assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> q == '0);
endmodule

// File: rtl/rxec_classifier.sv
module rxec_classifier
   import rxec_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int RES_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sof,
   input  logic             frame_end,
   input  logic             crc_ok,
   input  logic [RES_W-1:0] res_bits,
   input  logic             fifo_ovr,
   input  logic             no_buf,
   input  logic [2:0]       ctr_clr,
   output logic             buf_close,
   output logic [2:0]       st_flags,
   output logic             ev_rxf,
   output logic             ev_busy,
   output logic             hunt_cmd,
   output logic             hunting,
   output logic [CNT_W-1:0] cnt_discard,
   output logic [CNT_W-1:0] cnt_align,
   output logic [CNT_W-1:0] cnt_crc
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
      $error("rxec_classifier: CNT_W must lie in 2..32");
   end
   if (RES_W < 1 || RES_W > 4) begin : g_bad_res_w
      $error("rxec_classifier: RES_W must lie in 1..4");
   end

   act_t act;
   act_t act_q;
   logic [CNT_W-1:0] cnt_q [NUM_CNT];

   rxec_decide #(.RES_W(RES_W)) u_decide (
      .hunting   (hunting),
      .fifo_ovr  (fifo_ovr),
      .no_buf    (no_buf),
      .frame_end (frame_end),
      .crc_ok    (crc_ok),
      .res_bits  (res_bits),
      .act       (act)
   );

   rxec_hunt u_hunt (
      .clk     (clk),
      .rst_n   (rst_n),
      .enter   (act.hunt),
      .sof     (sof),
      .hunting (hunting)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_q <= '0;
      else        act_q <= act;
   end

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      rxec_satcnt #(.W(CNT_W)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (act.inc[i]),
         .clr   (ctr_clr[i]),
         .q     (cnt_q[i])
      );
   end

   assign buf_close   = act_q.close;
   assign ev_rxf      = act_q.rxf;
   assign ev_busy     = act_q.busy;
   assign hunt_cmd    = act_q.hunt;
   assign st_flags    = act_q.flags;
   assign cnt_discard = cnt_q[CNT_DISC];
   assign cnt_align   = cnt_q[CNT_ALGN];
   assign cnt_crc     = cnt_q[CNT_CRC];

   assert_flags_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(st_flags));
   assert_flags_need_close_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (|st_flags) |-> buf_close);
   assert_busy_no_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_busy |-> !buf_close && !ev_rxf);
   assert_hunt_cmd_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hunt_cmd |-> hunting);
   assert_ignore_in_hunt_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hunting && (frame_end || fifo_ovr || no_buf)) |=> !buf_close && !ev_busy);
endmodule

// File: tb/rxec_classifier_test.sv
`timescale 1ns/100ps
module rxec_classifier_test;
   localparam int CW  = 4;
   localparam int RW  = 3;
   localparam int TOP = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sof = 0, frame_end = 0, crc_ok = 0, fifo_ovr = 0, no_buf = 0;
   logic [RW-1:0] res_bits = '0;
   logic [2:0]    ctr_clr = '0;
   logic          buf_close, ev_rxf, ev_busy, hunt_cmd, hunting;
   logic [2:0]    st_flags;
   logic [CW-1:0] cnt_discard, cnt_align, cnt_crc;

   int checks = 0, failures = 0;
   bit done = 0;
   bit m_hunt = 0;
   int m_disc = 0, m_algn = 0, m_crc = 0;

   always #2.5 clk = ~clk;

   rxec_classifier #(.CNT_W(CW), .RES_W(RW)) uut (
      .clk(clk), .rst_n(rst_n), .sof(sof), .frame_end(frame_end), .crc_ok(crc_ok),
      .res_bits(res_bits), .fifo_ovr(fifo_ovr), .no_buf(no_buf), .ctr_clr(ctr_clr),
      .buf_close(buf_close), .st_flags(st_flags), .ev_rxf(ev_rxf), .ev_busy(ev_busy),
      .hunt_cmd(hunt_cmd), .hunting(hunting), .cnt_discard(cnt_discard),
      .cnt_align(cnt_align), .cnt_crc(cnt_crc)
   );

   function automatic logic [7:0] pack_ev(logic c, logic r, logic b, logic h,
                                          logic hs, logic [2:0] f);
      return {1'b0, c, r, b, h, hs, f[1:0]} ^ {f[2], 7'b0};
   endfunction

   task automatic compare(string tag, logic [7:0] ev_exp, logic [3*CW-1:0] c_exp);
      logic [7:0]      ev_act;
      logic [3*CW-1:0] c_act;
      ev_act = pack_ev(buf_close, ev_rxf, ev_busy, hunt_cmd, hunting, st_flags);
      c_act  = {cnt_discard, cnt_align, cnt_crc};
      checks++;
      if (ev_act !== ev_exp || c_act !== c_exp) begin
         failures++;
         $display("FAIL %s events act=%b exp=%b counters act=%h exp=%h",
                  tag, ev_act, ev_exp, c_act, c_exp);
      end
   endtask

   // one cycle of stimulus, model update and comparison
   task automatic step(string tag, bit ovr, bit nb, bit fe, bit ok, int res,
                       bit sf, logic [2:0] clr);
      bit c = 0, r = 0, b = 0, h = 0;
      logic [2:0] f = 3'b000;
      bit nh;
      if (!m_hunt) begin
         if (ovr) begin c = 1; r = 1; h = 1; f = 3'b001; if (m_disc < TOP) m_disc++; end
         else if (nb) begin b = 1; if (m_disc < TOP) m_disc++; end
         else if (fe) begin
            c = 1; r = 1;
            if (!ok && res != 0) begin f = 3'b100; if (m_algn < TOP) m_algn++; end
            else if (!ok) begin f = 3'b010; h = 1; if (m_crc < TOP) m_crc++; end
         end
      end
      if (clr[0]) m_disc = 0;
      if (clr[1]) m_algn = 0;
      if (clr[2]) m_crc  = 0;
      nh = h ? 1'b1 : (m_hunt && sf) ? 1'b0 : m_hunt;
      m_hunt = nh;
      @(negedge clk);
      fifo_ovr = ovr; no_buf = nb; frame_end = fe; crc_ok = ok;
      res_bits = RW'(res); sof = sf; ctr_clr = clr;
      @(posedge clk); #1;
      fifo_ovr = 0; no_buf = 0; frame_end = 0; sof = 0; ctr_clr = '0;
      compare(tag, pack_ev(c, r, b, h, nh, f),
              {CW'(m_disc), CW'(m_algn), CW'(m_crc)});
   endtask

   task automatic leave_hunt();
      step("R7 sof exits hunt", 0, 0, 0, 0, 0, 1, 3'b000);
   endtask

   initial begin
      #100000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      compare("R1 reset state", 8'h00, '0);
      @(negedge clk); rst_n = 1'b1;

      // R6, R5 and R4: every residual count with CRC pass and fail
      for (int res = 0; res < (1 << RW); res++) begin
         step("R6 crc ok frame", 0, 0, 1, 1, res, 0, 3'b000);
         if (res == 0) begin
            step("R4 aligned crc error", 0, 0, 1, 0, res, 0, 3'b000);
            step("R7 frame ignored in hunt", 0, 0, 1, 0, 0, 0, 3'b000);
            step("R7 overrun ignored in hunt", 1, 1, 0, 0, 0, 0, 3'b000);
            leave_hunt();
         end else begin
            step("R5 non-octet crc error", 0, 0, 1, 0, res, 0, 3'b000);
         end
      end

      // R2, R3, R8: all combinations of simultaneous strobes
      for (int v = 0; v < 16; v++) begin
         string t;
         t = v[3] ? "R2 overrun precedence R8" : v[2] ? "R3 busy precedence R8" : "R8 frame end only";
         step(t, v[3], v[2], v[1], v[0], 0, 0, 3'b000);
         if (m_hunt) leave_hunt();
      end

      // R10: clear wins over same-cycle increment, each counter alone
      step("R10 clear discard with busy", 0, 1, 0, 0, 0, 0, 3'b001);
      step("R10 clear align with align error", 0, 0, 1, 0, 2, 0, 3'b010);
      step("R4 crc error before clear", 0, 0, 1, 0, 0, 0, 3'b000);
      step("R10 clear crc while hunting", 0, 0, 0, 0, 0, 0, 3'b100);
      leave_hunt();

      // R9: drive every counter past saturation
      for (int k = 0; k < TOP + 4; k++) begin
         step("R9 align saturation", 0, 0, 1, 0, 1, 0, 3'b000);
         step("R9 discard saturation", 0, 1, 0, 0, 0, 0, 3'b000);
         step("R9 crc saturation", 0, 0, 1, 0, 0, 0, 3'b000);
         leave_hunt();
      end

      // R11: outputs return to zero on an idle cycle
      step("R11 idle pulse release", 0, 0, 0, 0, 0, 0, 3'b000);
      step("R10 clear all", 0, 0, 0, 0, 0, 0, 3'b111);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule